// File: doc/BRIEF.md
# Timeslot Sequencer Driven by Time of Day

This block converts a running time-of-day value into a repeating frame of numbered timeslots for a time-division scheme. The time arrives as one 128-bit word holding whole seconds, nanoseconds and fractions of a nanosecond. Four settings, in the same format, shape the frame:

- an absolute frame start time;
- a frame period;
- a slot period;
- an active window length, measured from the start of each slot.

Once enabled, the block follows the incoming time. It reports the current slot number, a pulse at every slot start, a pulse at every frame start, and a flag that is high during the active part of a slot and low during the guard gap that ends it.

All upcoming boundaries are held as absolute timestamps. Each new boundary is made by adding a period to the boundary before it, and every frame restarts its slot timing from the frame boundary. As a result, slot and window rounding never builds up from one frame to the next. A frame boundary overrides a slot boundary, and a slot boundary overrides the end of the active window. Two status flags are provided: `locked` shows that boundaries are being tracked, and `error` reports a forward time jump that could not be followed.

Top module: `tdma_slot_sequencer`

## Requirements
- R1: The first frame starts at the first time value at or after the start setting. Each later frame starts one frame period after the previous frame boundary. A frame start raises `sched_start` and `slot_start` for one cycle, with `slot_idx` = 0.
- R2: Within a frame, each time the time reaches the previous slot boundary plus the slot period, `slot_start` pulses for one cycle and `slot_idx` goes up by one. Between these events `slot_idx` holds its value.
- R3: `slot_active` rises with every slot start. It falls once the time reaches the slot boundary plus the active length, and stays low for the rest of that slot.
- R4: A frame boundary wins over a pending slot boundary. If slots do not fit evenly, the last slot is cut short and `slot_idx` returns to 0.
- R5: A slot boundary wins over the end of the active window. If the active length is not shorter than the slot period, `slot_active` stays high with no gap.
- R6: `locked` is low after reset and while waiting for the start time. It rises with the first frame start. `slot_start` never pulses while `locked` is low.
- R7: If the time is already at or past the pending frame boundary plus one frame period, `error` rises and `locked` falls. The block then walks forward from the start setting, one frame period per cycle, and locks again at the next frame boundary. `error` stays high until R9 clears it.
- R8: `slot_idx` counts from 0 to NUM_SLOTS-1 and then wraps to 0 with a plain `slot_start`, even when the frame period has not yet ended.
- R9: When `enable` is low, or in any cycle with `cfg_update` high, the next cycle shows `locked`, `error`, `slot_active` and `slot_idx` all at 0. Tracking then restarts from the start setting.
- R10: Every time word has seconds in bits [127:64], nanoseconds (0 to 999,999,999) in bits [63:32] and fractional nanoseconds in bits [31:0]. Adding a period carries fractions into nanoseconds, and carries nanoseconds into seconds at 1,000,000,000.
- R11: In a cycle with `tod_valid` low, no boundary is taken and all tracking state holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| enable | input | 1 | Run the sequencer |
| cfg_update | input | 1 | One-cycle pulse: settings changed, restart tracking |
| tod_valid | input | 1 | Time-of-day value is valid |
| tod | input | 128 | Current time of day |
| start_time | input | 128 | Absolute time of the first frame |
| frame_period | input | 128 | Frame period |
| slot_period | input | 128 | Slot period |
| active_len | input | 128 | Active window length from slot start |
| slot_idx | output | $clog2(NUM_SLOTS) | Current slot number |
| slot_start | output | 1 | One-cycle pulse at each slot start |
| sched_start | output | 1 | One-cycle pulse at each frame start |
| slot_active | output | 1 | High during the active window, low in the guard gap |
| locked | output | 1 | Boundaries are being tracked |
| error | output | 1 | A time jump could not be followed |

## Verification
Some rules are checked on every cycle:

- a frame start always comes with slot 0;
- a plain slot start steps the index by one and wraps it after the last slot;
- the index stays in range and holds between slot starts;
- every slot start coincides with `locked` and a raised active flag;
- a disable or update clears everything on the next cycle;
- no slot start follows an invalid time.

Other behaviour only shows in the bench scenarios, because it depends on timestamp arithmetic:

- boundaries landing at exact absolute times;
- a cut-short last slot;
- a missing guard gap when the window outlasts the slot;
- recovery after a forward time jump;
- frames carried cleanly across a seconds rollover.

// File: rtl/tdma_pkg.sv
package tdma_pkg;

    localparam int SEC_W  = 64;
    localparam int NS_W   = 32;
    localparam int FRAC_W = 32;
    localparam int TS_W   = SEC_W + NS_W + FRAC_W;
    localparam int NS_PER_SEC = 1_000_000_000;
    localparam logic [NS_W:0] NS_MOD = (NS_W + 1)'(NS_PER_SEC);

    typedef struct packed {
        logic [SEC_W-1:0]  sec;
        logic [NS_W-1:0]   ns;
        logic [FRAC_W-1:0] frac;
    } tstamp_t;

    typedef enum logic [1:0] {
        ST_OFF  = 2'd0,
        ST_SEEK = 2'd1,
        ST_RUN  = 2'd2
    } seq_state_t;

    // Sum of two timestamps; nanoseconds wrap at one second.
    function automatic tstamp_t ts_add(input tstamp_t a, input tstamp_t b);
        tstamp_t           r;
        logic [FRAC_W:0]   f;
        logic [NS_W:0]     n;
        logic              carry;
        f = {1'b0, a.frac} + {1'b0, b.frac};
        n = {1'b0, a.ns} + {1'b0, b.ns} + {{NS_W{1'b0}}, f[FRAC_W]};
        carry = (n >= NS_MOD);
        r.frac = f[FRAC_W-1:0];
        r.ns   = carry ? NS_W'(n - NS_MOD) : n[NS_W-1:0];
        r.sec  = a.sec + b.sec + SEC_W'(carry);
        return r;
    endfunction

    // With normalised nanoseconds the packed word orders like time.
    function automatic logic ts_ge(input tstamp_t a, input tstamp_t b);
        return a >= b;
    endfunction

endpackage

// File: rtl/tdma_ts_add.sv
module tdma_ts_add
    import tdma_pkg::*;
(
    input  tstamp_t a,
    input  tstamp_t b,
    output tstamp_t y
);
    assign y = ts_add(a, b);
endmodule

// File: rtl/tdma_slot_counter.sv
module tdma_slot_counter #(
    parameter int NUM_SLOTS = 4,
    localparam int IDX_W = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             adv,
    output logic [IDX_W-1:0] idx
);
    localparam logic [IDX_W-1:0] LAST = IDX_W'(NUM_SLOTS - 1);

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            idx <= '0;
        end else if (adv) begin
            idx <= (idx == LAST) ? '0 : idx + 1'b1;
        end
    end
endmodule

// File: rtl/tdma_slot_sequencer.sv
module tdma_slot_sequencer
    import tdma_pkg::*;
#(
    parameter int NUM_SLOTS = 4,
    localparam int IDX_W = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              enable,
    input  logic              cfg_update,
    input  logic              tod_valid,
    input  logic [TS_W-1:0]   tod,
    input  logic [TS_W-1:0]   start_time,
    input  logic [TS_W-1:0]   frame_period,
    input  logic [TS_W-1:0]   slot_period,
    input  logic [TS_W-1:0]   active_len,
    output logic [IDX_W-1:0]  slot_idx,
    output logic              slot_start,
    output logic              sched_start,
    output logic              slot_active,
    output logic              locked,
    output logic              error
);
    // Adder slots: frame+frameP, frame+slotP, frame+activeL, slot+slotP, slot+activeL
    localparam int N_ADD = 5;
    localparam int A_FRM_NEXT = 0;
    localparam int A_FRM_SLOT = 1;
    localparam int A_FRM_ACT  = 2;
    localparam int A_SLT_NEXT = 3;
    localparam int A_SLT_ACT  = 4;

    seq_state_t state;
    tstamp_t    nxt_frame, nxt_slot, act_end;
    tstamp_t    now, p_frame, p_slot, p_act;
    tstamp_t    add_a [N_ADD];
    tstamp_t    add_b [N_ADD];
    tstamp_t    add_y [N_ADD];

    assign now     = tstamp_t'(tod);
    assign p_frame = tstamp_t'(frame_period);
    assign p_slot  = tstamp_t'(slot_period);
    assign p_act   = tstamp_t'(active_len);

    always_comb begin
        add_a[A_FRM_NEXT] = nxt_frame; add_b[A_FRM_NEXT] = p_frame;
        add_a[A_FRM_SLOT] = nxt_frame; add_b[A_FRM_SLOT] = p_slot;
        add_a[A_FRM_ACT]  = nxt_frame; add_b[A_FRM_ACT]  = p_act;
        add_a[A_SLT_NEXT] = nxt_slot;  add_b[A_SLT_NEXT] = p_slot;
        add_a[A_SLT_ACT]  = nxt_slot;  add_b[A_SLT_ACT]  = p_act;
    end

    generate
        for (genvar g = 0; g < N_ADD; g++) begin : g_add
            tdma_ts_add u_add (.a(add_a[g]), .b(add_b[g]), .y(add_y[g]));
        end
    endgenerate

    // Boundary comparisons against the current time
    logic hit_frame, overrun, hit_slot, hit_act;
    assign hit_frame = ts_ge(now, nxt_frame);
    assign overrun   = ts_ge(now, add_y[A_FRM_NEXT]);
    assign hit_slot  = ts_ge(now, nxt_slot);
    assign hit_act   = ts_ge(now, act_end);

    // Event decode, outer boundary first
    logic go_off, live, fire, jump, adv;
    assign go_off = !enable || cfg_update;
    assign live   = !go_off && tod_valid;
    assign fire   = live && (state != ST_OFF) && hit_frame && !overrun;
    assign jump   = live && (state == ST_RUN) && overrun;
    assign adv    = live && (state == ST_RUN) && !hit_frame && hit_slot;

    tdma_slot_counter #(.NUM_SLOTS(NUM_SLOTS)) u_cnt (
        .clk (clk),
        .rst (rst),
        .clr (go_off || fire || jump),
        .adv (adv),
        .idx (slot_idx)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state       <= ST_OFF;
            nxt_frame   <= '0;
            nxt_slot    <= '0;
            act_end     <= '0;
            slot_start  <= 1'b0;
            sched_start <= 1'b0;
            slot_active <= 1'b0;
            locked      <= 1'b0;
            error       <= 1'b0;
        end else begin
            slot_start  <= fire || adv;
            sched_start <= fire;
            if (go_off) begin
                state       <= ST_OFF;
                locked      <= 1'b0;
                error       <= 1'b0;
                slot_active <= 1'b0;
            end else if (state == ST_OFF) begin
                nxt_frame <= tstamp_t'(start_time);
                state     <= ST_SEEK;
            end else if (tod_valid) begin
                if (overrun) begin
                    if (state == ST_SEEK) begin
                        nxt_frame <= add_y[A_FRM_NEXT];
                    end else begin
                        error       <= 1'b1;
                        locked      <= 1'b0;
                        slot_active <= 1'b0;
                        nxt_frame   <= tstamp_t'(start_time);
                        state       <= ST_SEEK;
                    end
                end else if (hit_frame) begin
                    nxt_frame   <= add_y[A_FRM_NEXT];
                    nxt_slot    <= add_y[A_FRM_SLOT];
                    act_end     <= add_y[A_FRM_ACT];
                    slot_active <= 1'b1;
                    locked      <= 1'b1;
                    state       <= ST_RUN;
                end else if (state == ST_RUN) begin
                    if (hit_slot) begin
                        nxt_slot    <= add_y[A_SLT_NEXT];
                        act_end     <= add_y[A_SLT_ACT];
                        slot_active <= 1'b1;
                    end else if (hit_act) begin
                        slot_active <= 1'b0;
                    end
                end
            end
        end
    end
endmodule

// File: rtl/tdma_seq_checker.sv
module tdma_seq_checker #(
    parameter int NUM_SLOTS = 4,
    localparam int IDX_W = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1
) (
    input logic             clk,
    input logic             rst,
    input logic             enable,
    input logic             cfg_update,
    input logic             tod_valid,
    input logic [IDX_W-1:0] slot_idx,
    input logic             slot_start,
    input logic             sched_start,
    input logic             slot_active,
    input logic             locked,
    input logic             error
);
    assert_frame_slot0_R1: assert property (@(posedge clk) disable iff (rst)
        sched_start |-> (slot_start && slot_idx == '0));

    assert_slot_step_R2: assert property (@(posedge clk) disable iff (rst)
        (slot_start && !sched_start) |->
            (int'(slot_idx) == ((int'($past(slot_idx)) == NUM_SLOTS - 1) ? 0 : int'($past(slot_idx)) + 1)));

    assert_idx_hold_R2: assert property (@(posedge clk) disable iff (rst)
        (locked && $past(locked) && !slot_start) |-> $stable(slot_idx));

    assert_start_active_R3: assert property (@(posedge clk) disable iff (rst)
        slot_start |-> slot_active);

    assert_pulse_locked_R6: assert property (@(posedge clk) disable iff (rst)
        slot_start |-> locked);

    assert_err_unlock_R7: assert property (@(posedge clk) disable iff (rst)
        $rose(error) |-> !locked);

    assert_idx_range_R8: assert property (@(posedge clk) disable iff (rst)
        int'(slot_idx) < NUM_SLOTS);

    assert_off_clears_R9: assert property (@(posedge clk) disable iff (rst)
        (!enable || cfg_update) |=> (!locked && !error && !slot_active && !slot_start && slot_idx == '0));

    assert_invalid_quiet_R11: assert property (@(posedge clk) disable iff (rst)
        !tod_valid |=> !slot_start);
endmodule

bind tdma_slot_sequencer tdma_seq_checker #(.NUM_SLOTS(NUM_SLOTS)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .enable      (enable),
    .cfg_update  (cfg_update),
    .tod_valid   (tod_valid),
    .slot_idx    (slot_idx),
    .slot_start  (slot_start),
    .sched_start (sched_start),
    .slot_active (slot_active),
    .locked      (locked),
    .error       (error)
);

// File: tb/sim_tdma_slot_sequencer.sv
module sim_tdma_slot_sequencer;
    localparam int N = 4;
    localparam bit [127:0] NS = 128'd1 << 32;   // one nanosecond in linear units

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic enable = 1'b0, cfg_update = 1'b0, tod_valid = 1'b1;
    logic [127:0] tod = '0, start_time = '0, frame_period = '0, slot_period = '0, active_len = '0;
    logic [1:0] slot_idx;
    logic slot_start, sched_start, slot_active, locked, error;

    always #4 clk = ~clk;

    tdma_slot_sequencer #(.NUM_SLOTS(N)) u0 (
        .clk(clk), .rst(rst), .enable(enable), .cfg_update(cfg_update), .tod_valid(tod_valid),
        .tod(tod), .start_time(start_time), .frame_period(frame_period),
        .slot_period(slot_period), .active_len(active_len),
        .slot_idx(slot_idx), .slot_start(slot_start), .sched_start(sched_start),
        .slot_active(slot_active), .locked(locked), .error(error)
    );

    int n_chk = 0, n_bad = 0;
    bit done = 0;

    // Linear time: ((sec*1e9 + ns) << 32) + frac
    function automatic bit [127:0] to_lin(input logic [127:0] t);
        bit [127:0] s;
        s = 128'(t[127:64]);
        return ((s * 128'd1000000000 + 128'(t[63:32])) << 32) + 128'(t[31:0]);
    endfunction

    function automatic logic [127:0] from_lin(input bit [127:0] l);
        bit [127:0] tn, sc, ns;
        tn = l >> 32;
        sc = tn / 128'd1000000000;
        ns = tn % 128'd1000000000;
        return {sc[63:0], ns[31:0], l[31:0]};
    endfunction

    task automatic chk(input string tag, input longint act, input longint exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    // Reference model in linear arithmetic
    int m_st, m_idx;
    bit [127:0] m_nf, m_ns, m_ae;
    bit m_ss, m_sch, m_act, m_lock, m_err;

    always @(posedge clk) begin
        bit [127:0] t, P, S, A;
        t = to_lin(tod); P = to_lin(frame_period); S = to_lin(slot_period); A = to_lin(active_len);
        if (rst) begin
            m_st = 0; m_idx = 0; m_nf = 0; m_ns = 0; m_ae = 0;
            m_ss = 0; m_sch = 0; m_act = 0; m_lock = 0; m_err = 0;
        end else begin
            m_ss = 0; m_sch = 0;
            if (!enable || cfg_update) begin
                m_st = 0; m_lock = 0; m_err = 0; m_act = 0; m_idx = 0;
            end else if (m_st == 0) begin
                m_nf = to_lin(start_time); m_st = 1;
            end else if (tod_valid) begin
                if (t >= m_nf + P) begin
                    if (m_st == 1) m_nf = m_nf + P;
                    else begin
                        m_err = 1; m_lock = 0; m_act = 0; m_idx = 0;
                        m_nf = to_lin(start_time); m_st = 1;
                    end
                end else if (t >= m_nf) begin
                    m_ss = 1; m_sch = 1; m_idx = 0; m_act = 1; m_lock = 1;
                    m_ns = m_nf + S; m_ae = m_nf + A; m_nf = m_nf + P; m_st = 2;
                end else if (m_st == 2) begin
                    if (t >= m_ns) begin
                        m_ss = 1; m_idx = (m_idx == N - 1) ? 0 : m_idx + 1; m_act = 1;
                        m_ae = m_ns + A; m_ns = m_ns + S;
                    end else if (t >= m_ae) m_act = 0;
                end
            end
        end
    end

    // Stimulus state and observations taken from the ports
    bit [127:0] tod_lin;
    int ob_frames, ob_guard, ob_wrap, ob_err, ob_ss, run_len;
    int max_len [N];

    task automatic clear_obs();
        ob_frames = 0; ob_guard = 0; ob_wrap = 0; ob_err = 0; ob_ss = 0; run_len = 0;
        for (int i = 0; i < N; i++) max_len[i] = 0;
    endtask

    task automatic cyc();
        @(negedge clk);
        if (!rst) begin
            chk("R1 sched_start", longint'(sched_start), longint'(m_sch));
            chk("R2 slot_start", longint'(slot_start), longint'(m_ss));
            chk("R2 slot_idx", longint'(slot_idx), longint'(m_idx));
            chk("R3 slot_active", longint'(slot_active), longint'(m_act));
            chk("R6 locked", longint'(locked), longint'(m_lock));
            chk("R7 error", longint'(error), longint'(m_err));
        end
        if (sched_start) ob_frames++;
        if (slot_start) ob_ss++;
        if (slot_start && !sched_start && slot_idx == 2'd0) ob_wrap++;
        if (locked && !slot_active) ob_guard++;
        if (error) ob_err++;
        if (slot_start) run_len = 1; else if (locked) run_len++;
        if (locked && run_len > max_len[slot_idx]) max_len[slot_idx] = run_len;
        cfg_update = 1'b0;
        tod_lin = tod_lin + 8 * NS + 128'($urandom_range(0, 32'hFFFF_FFFF) >> 4);
        tod = from_lin(tod_lin);
    endtask

    task automatic run(input int n);
        for (int i = 0; i < n; i++) cyc();
    endtask

    task automatic setcfg(input bit [127:0] st, input bit [127:0] p, input bit [127:0] s, input bit [127:0] a);
        start_time = from_lin(st); frame_period = from_lin(p);
        slot_period = from_lin(s); active_len = from_lin(a);
        cfg_update = 1'b1;
        clear_obs();
    endtask

    function automatic bit [127:0] rfrac();
        return 128'($urandom_range(0, 32'hFFFF_FFFF));
    endfunction

    initial begin
        void'($urandom(32'd97));
        tod_lin = 900 * NS;
        tod = from_lin(tod_lin);
        clear_obs();
        run(3);
        rst = 1'b0;
        cyc();
        // Reset state (R6)
        chk("R6 locked after reset", longint'(locked), 0);
        chk("R6 slot_idx after reset", longint'(slot_idx), 0);
        chk("R9 error after reset", longint'(error), 0);

        // Basic frames: 4 slots of 100 ns with 70 ns windows (R1, R3)
        setcfg(1000 * NS, 400 * NS + rfrac(), 100 * NS, 70 * NS);
        enable = 1'b1;
        run(400);
        chk("R1 frames seen", longint'(ob_frames >= 4), 1);
        chk("R3 guard gap seen", longint'(ob_guard > 0), 1);

        // Uneven fit: last slot cut short (R4)
        setcfg(tod_lin + 200 * NS, 350 * NS, 100 * NS + rfrac(), 60 * NS);
        run(400);
        chk("R4 frames seen", longint'(ob_frames >= 3), 1);
        chk("R4 last slot shorter", longint'(max_len[3] < max_len[1]), 1);

        // Window longer than slot: no guard gap (R5)
        setcfg(tod_lin + 200 * NS, 400 * NS, 100 * NS, 150 * NS + rfrac());
        run(300);
        chk("R5 no guard gap", longint'(ob_guard), 0);

        // More slot periods than slots: index wraps without frame (R8)
        setcfg(tod_lin + 200 * NS, 700 * NS, 100 * NS, 50 * NS);
        run(400);
        chk("R8 wrap without frame", longint'(ob_wrap > 0), 1);

        // Forward jump beyond one frame period (R7)
        setcfg(tod_lin + 200 * NS, 400 * NS + rfrac(), 100 * NS, 70 * NS);
        run(150);
        tod_lin = tod_lin + 2000 * NS;
        tod = from_lin(tod_lin);
        run(2);
        chk("R7 error raised", longint'(error), 1);
        chk("R7 lock dropped", longint'(locked), 0);
        run(200);
        chk("R7 relocked", longint'(locked), 1);
        chk("R7 error held", longint'(error), 1);

        // Disable and update both clear (R9)
        enable = 1'b0;
        cyc();
        chk("R9 locked cleared", longint'(locked), 0);
        chk("R9 error cleared", longint'(error), 0);
        chk("R9 active cleared", longint'(slot_active), 0);
        chk("R9 index cleared", longint'(slot_idx), 0);
        enable = 1'b1;
        run(150);
        cfg_update = 1'b1;
        cyc();
        chk("R9 update clears lock", longint'(locked), 0);
        run(100);

        // Tracking through a seconds rollover (R10)
        tod_lin = ((128'd5 * 128'd1000000000) + 128'd999999000) * NS;
        tod = from_lin(tod_lin);
        setcfg(tod_lin + 100 * NS, 400 * NS + rfrac(), 100 * NS + rfrac(), 70 * NS + rfrac());
        run(300);
        chk("R10 second rolled", longint'(tod[127:64]), 6);
        chk("R10 frames across rollover", longint'(ob_frames >= 4), 1);

        // Invalid time holds everything (R11)
        tod_valid = 1'b0;
        ob_ss = 0;
        run(20);
        chk("R11 no slot start while invalid", longint'(ob_ss), 0);
        tod_valid = 1'b1;
        run(100);

        // Constrained random settings
        for (int k = 0; k < 4; k++) begin
            int s, p, a;
            s = $urandom_range(40, 150);
            p = s * $urandom_range(2, 6) + $urandom_range(0, 30);
            a = $urandom_range(10, s + 50);
            setcfg(tod_lin + 150 * NS, 128'(p) * NS + rfrac(), 128'(s) * NS + rfrac(), 128'(a) * NS + rfrac());
            run(250);
            chk("R1 random frames", longint'(ob_frames >= 1), 1);
        end

        done = 1;
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        #(8 * 150000);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end
endmodule